// File: doc/BRIEF.md
# Segmented Data Memory Address Unit

This unit converts 8-bit data addresses into physical addresses for a 1024-byte data RAM in a small 8-bit controller. It owns four pointer registers: two general pointers (B and X), a stack pointer (SP) and a segment register (S). Each access selects one of four address sources: an address from the instruction, the B pointer, the X pointer or the stack pointer. The lower half of the 8-bit space (00h–7Fh) is banked by S. The upper half (80h–FFh) is the same for every value of S.

The four pointers also sit in the register window at the top of the base page, so ordinary loads and stores can reach them. The unit flags any access that lands on one of those four addresses. On a read it returns the pointer value, and on a write it loads the pointer. The RAM array itself and any other register decoding live outside the unit. Physical address, window flag and read value are combinational from the current request. Pointer updates take effect at the next rising clock edge.

Top module: `dmem_addr_unit`

## Requirements
- R1: After reset, X, B and S read as 00h and SP reads as 6Fh.
- R2: An access whose logical address is in 00h–7Fh drives phys_addr_o = (S·128 + address) mod 1024.
- R3: An access whose logical address is in 80h–FFh drives phys_addr_o equal to that address, for any S.
- R4: Logical addresses FCh, FDh, FEh and FFh are X, SP, B and S. A valid access there raises ptr_hit_o and returns the pointer on ptr_rdata_o; a write access there loads wdata_i into the pointer at the next edge. ptr_hit_o is 0 and ptr_rdata_o is 00h for any other address or when acc_valid_i is 0.
- R5: acc_mode_i selects the logical address: 0 = dir_addr_i, 1 = B, 2 = X, 3 = SP. Indirect addresses are then mapped as in R2 and R3.
- R6: For acc_mode_i 1 or 2, post_op_i 1 adds one to the pointer used and post_op_i 2 subtracts one, after the access has used the old value. Codes 0 and 3 leave the pointer unchanged.
- R7: Post-increment and post-decrement of B and X wrap modulo 256.
- R8: post_op_i has no effect in modes 0 and 3, and SP never steps.
- R9: When a window write targets the same pointer that a post-modify would change, the written value wins.
- R10: With acc_valid_i at 0, no pointer changes, whatever the other inputs are.
- R11: A read access (we_i = 0) to the window leaves the pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access request this cycle |
| acc_mode_i | input | 2 | Address source: 0 direct, 1 B, 2 X, 3 SP |
| dir_addr_i | input | 8 | Direct address from the instruction |
| post_op_i | input | 2 | Pointer post-modify: 0 none, 1 increment, 2 decrement, 3 none |
| we_i | input | 1 | Access is a write |
| wdata_i | input | 8 | Write data |
| phys_addr_o | output | AW (10) | Physical RAM address |
| ptr_hit_o | output | 1 | Access targets a mapped pointer |
| ptr_rdata_o | output | 8 | Pointer value for a window access |

## Verification
The properties check these rules on every cycle: the mapping of direct addresses in both halves of the space, the window flag for direct addresses FCh–FFh, freezing of all pointers while idle, single steps of B and X, a write winning over a step, SP staying fixed under stack accesses, and S staying fixed on reads. The rest can only be shown by the bench's scenarios: reset values seen through the window, the full sweep of all 256 segments against all 256 direct addresses, indirect mapping over every B value, wrap-around after many steps, and the reserved post-modify code.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int DW   = 8;
  localparam int NPTR = 4;

  typedef enum logic [1:0] {
    ACC_DIR = 2'd0,
    ACC_B   = 2'd1,
    ACC_X   = 2'd2,
    ACC_SP  = 2'd3
  } acc_mode_e;

  typedef enum logic [1:0] {
    POST_NONE = 2'd0,
    POST_INC  = 2'd1,
    POST_DEC  = 2'd2,
    POST_RSV  = 2'd3
  } post_op_e;

  // slot = low two bits of the window address
  localparam logic [1:0] SLOT_X  = 2'd0;
  localparam logic [1:0] SLOT_SP = 2'd1;
  localparam logic [1:0] SLOT_B  = 2'd2;
  localparam logic [1:0] SLOT_S  = 2'd3;

  localparam logic [DW-3:0] WIN_TAG = '1;   // FCh..FFh
  localparam logic [DW-1:0] SP_RST  = 8'h6F;
endpackage

// File: rtl/dmem_ptr_step.sv
module dmem_ptr_step
  import dmem_pkg::*;
(
  input  logic [DW-1:0] cur_i,
  input  post_op_e      op_i,
  output logic [DW-1:0] nxt_o
);
  always_comb begin
    case (op_i)
      POST_INC: nxt_o = cur_i + 1'b1;
      POST_DEC: nxt_o = cur_i - 1'b1;
      default:  nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/dmem_seg_map.sv
module dmem_seg_map
  import dmem_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic [DW-1:0] log_i,
  input  logic [DW-1:0] seg_i,
  output logic [AW-1:0] phys_o
);
  localparam int OFS_W = DW - 1;

  logic [AW-1:0] seg_phys;
  assign seg_phys = AW'({seg_i, log_i[OFS_W-1:0]});
  assign phys_o   = log_i[DW-1] ? AW'(log_i) : seg_phys;
endmodule

// File: rtl/dmem_ptr_bank.sv
module dmem_ptr_bank
  import dmem_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NPTR-1:0]     wr_en_i,
  input  logic [DW-1:0]       wr_data_i,
  input  logic [NPTR-1:0]     mod_en_i,
  input  logic [DW-1:0]       mod_data_i,
  output logic [DW-1:0]       ptr_o [NPTR]
);
  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    localparam logic [DW-1:0] RST_VAL = (g == int'(SLOT_SP)) ? SP_RST : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          ptr_o[g] <= RST_VAL;
      else if (wr_en_i[g])  ptr_o[g] <= wr_data_i;   // write beats post-modify
      else if (mod_en_i[g]) ptr_o[g] <= mod_data_i;
    end
  end
endmodule

// File: rtl/dmem_addr_unit.sv
module dmem_addr_unit
  import dmem_pkg::*;
#(
  parameter  int RAM_BYTES = 1024,
  localparam int AW        = $clog2(RAM_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_valid_i,
  input  logic [1:0]    acc_mode_i,
  input  logic [7:0]    dir_addr_i,
  input  logic [1:0]    post_op_i,
  input  logic          we_i,
  input  logic [7:0]    wdata_i,
  output logic [AW-1:0] phys_addr_o,
  output logic          ptr_hit_o,
  output logic [7:0]    ptr_rdata_o
);
  acc_mode_e         mode;
  post_op_e          op;
  logic [DW-1:0]     ptr_q [NPTR];
  logic [DW-1:0]     log_addr;
  logic [1:0]        slot;
  logic [NPTR-1:0]   wr_en;
  logic [NPTR-1:0]   mod_en;
  logic [DW-1:0]     step_src;
  logic [DW-1:0]     step_val;
  logic              step_en;
  logic [DW-1:0]     x_q, sp_q, b_q, s_q;

  assign mode = acc_mode_e'(acc_mode_i);
  assign op   = post_op_e'(post_op_i);

  assign x_q  = ptr_q[SLOT_X];
  assign sp_q = ptr_q[SLOT_SP];
  assign b_q  = ptr_q[SLOT_B];
  assign s_q  = ptr_q[SLOT_S];

  always_comb begin
    case (mode)
      ACC_B:   log_addr = b_q;
      ACC_X:   log_addr = x_q;
      ACC_SP:  log_addr = sp_q;
      default: log_addr = dir_addr_i;
    endcase
  end

  assign slot      = log_addr[1:0];
  assign ptr_hit_o = acc_valid_i && (log_addr[DW-1:2] == WIN_TAG);
  assign ptr_rdata_o = ptr_hit_o ? ptr_q[slot] : '0;

  // one stepper shared by B and X: only one is addressed per access
  assign step_src = (mode == ACC_X) ? x_q : b_q;
  assign step_en  = acc_valid_i && ((mode == ACC_B) || (mode == ACC_X)) &&
                    ((op == POST_INC) || (op == POST_DEC));

  dmem_ptr_step u_step (
    .cur_i (step_src),
    .op_i  (op),
    .nxt_o (step_val)
  );

  for (genvar g = 0; g < NPTR; g++) begin : g_en
    assign wr_en[g]  = we_i && ptr_hit_o && (slot == 2'(g));
    assign mod_en[g] = step_en &&
                       (((g == int'(SLOT_B)) && (mode == ACC_B)) ||
                        ((g == int'(SLOT_X)) && (mode == ACC_X)));
  end

  dmem_ptr_bank u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_data_i  (wdata_i),
    .mod_en_i   (mod_en),
    .mod_data_i (step_val),
    .ptr_o      (ptr_q)
  );

  dmem_seg_map #(.AW(AW)) u_map (
    .log_i  (log_addr),
    .seg_i  (s_q),
    .phys_o (phys_addr_o)
  );
endmodule

// File: rtl/dmem_addr_unit_chk.sv
module dmem_addr_unit_chk #(
  parameter int AW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          acc_valid_i,
  input logic [1:0]    acc_mode_i,
  input logic [7:0]    dir_addr_i,
  input logic [1:0]    post_op_i,
  input logic          we_i,
  input logic [7:0]    wdata_i,
  input logic [AW-1:0] phys_addr_o,
  input logic          ptr_hit_o,
  input logic [7:0]    x_q,
  input logic [7:0]    sp_q,
  input logic [7:0]    b_q,
  input logic [7:0]    s_q
);
  AST_UPPER_FLAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_mode_i == 2'd0 && dir_addr_i[7] |-> phys_addr_o == AW'(dir_addr_i)); // R3

  AST_LOWER_SEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_mode_i == 2'd0 && !dir_addr_i[7] |->
      phys_addr_o[6:0] == dir_addr_i[6:0] && phys_addr_o[AW-1:7] == s_q[AW-8:0]); // R2

  AST_WIN_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_mode_i == 2'd0 && dir_addr_i >= 8'hFC |-> ptr_hit_o); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> $stable(x_q) && $stable(sp_q) && $stable(b_q) && $stable(s_q)); // R10

  AST_B_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_mode_i == 2'd1 && post_op_i == 2'd1 && !we_i |=> b_q == $past(b_q) + 8'd1); // R6

  AST_X_DEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_mode_i == 2'd2 && post_op_i == 2'd2 && !we_i |=> x_q == $past(x_q) - 8'd1); // R7

  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && we_i && acc_mode_i == 2'd1 && b_q == 8'hFE && post_op_i != 2'd0
      |=> b_q == $past(wdata_i)); // R9

  AST_SP_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_mode_i == 2'd3 && !we_i |=> $stable(sp_q)); // R8

  AST_READ_KEEPS_S: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && !we_i |=> $stable(s_q)); // R11
endmodule

bind dmem_addr_unit dmem_addr_unit_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_mode_i  (acc_mode_i),
  .dir_addr_i  (dir_addr_i),
  .post_op_i   (post_op_i),
  .we_i        (we_i),
  .wdata_i     (wdata_i),
  .phys_addr_o (phys_addr_o),
  .ptr_hit_o   (ptr_hit_o),
  .x_q         (x_q),
  .sp_q        (sp_q),
  .b_q         (b_q),
  .s_q         (s_q)
);

// File: tb/dmem_addr_unit_test.sv
module dmem_addr_unit_test;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          acc_valid_i = 1'b0;
  logic [1:0]    acc_mode_i = '0;
  logic [7:0]    dir_addr_i = '0;
  logic [1:0]    post_op_i = '0;
  logic          we_i = 1'b0;
  logic [7:0]    wdata_i = '0;
  logic [AW-1:0] phys_addr_o;
  logic          ptr_hit_o;
  logic [7:0]    ptr_rdata_o;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  // bench model of pointers: index 0 X, 1 SP, 2 B, 3 S
  int  m_ptr [4];

  always #4 clk = ~clk;   // 125 MHz

  dmem_addr_unit uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .acc_valid_i (acc_valid_i),
    .acc_mode_i  (acc_mode_i),
    .dir_addr_i  (dir_addr_i),
    .post_op_i   (post_op_i),
    .we_i        (we_i),
    .wdata_i     (wdata_i),
    .phys_addr_o (phys_addr_o),
    .ptr_hit_o   (ptr_hit_o),
    .ptr_rdata_o (ptr_rdata_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one access; compares combinational outputs, then advances the model
  task automatic acc(input bit v, input int m, input int a, input int p,
                     input bit w, input int d);
    int    lg, eph, slot;
    bit    ehit;
    int    erd;
    string tag;
    lg   = (m == 0) ? a : (m == 1) ? m_ptr[2] : (m == 2) ? m_ptr[0] : m_ptr[1];
    eph  = (lg >= 128) ? lg : (m_ptr[3] * 128 + lg) % 1024;
    ehit = v && (lg >= 252);
    slot = lg % 4;
    erd  = ehit ? m_ptr[slot] : 0;
    tag  = (m == 0) ? ((lg >= 128) ? "R3" : "R2") : ((m == 3) ? "R8" : "R5");
    @(negedge clk);
    acc_valid_i = v;
    acc_mode_i  = 2'(m);
    dir_addr_i  = 8'(a);
    post_op_i   = 2'(p);
    we_i        = w;
    wdata_i     = 8'(d);
    #1;
    chk(int'(phys_addr_o) == eph, tag, int'(phys_addr_o), eph);
    chk(ptr_hit_o == ehit, "R4 hit", int'(ptr_hit_o), int'(ehit));
    chk(int'(ptr_rdata_o) == erd, "R4 rdata", int'(ptr_rdata_o), erd);
    if (v) begin
      if ((m == 1 || m == 2) && (p == 1 || p == 2)) begin
        int idx;
        idx = (m == 1) ? 2 : 0;
        m_ptr[idx] = (p == 1) ? (m_ptr[idx] + 1) % 256 : (m_ptr[idx] + 255) % 256;
      end
      if (w && ehit) m_ptr[slot] = d % 256;
    end
    @(posedge clk);
  endtask

  // direct window read against a value fixed by the scenario
  task automatic rd(input int a, input int exp, input string tag);
    @(negedge clk);
    acc_valid_i = 1'b1;
    acc_mode_i  = 2'd0;
    dir_addr_i  = 8'(a);
    post_op_i   = 2'd0;
    we_i        = 1'b0;
    #1;
    chk(int'(ptr_rdata_o) == exp, tag, int'(ptr_rdata_o), exp);
    @(posedge clk);
    acc_valid_i = 1'b0;
  endtask

  initial begin
    m_ptr[0] = 0; m_ptr[1] = 'h6F; m_ptr[2] = 0; m_ptr[3] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(ptr_hit_o == 1'b0, "R4 idle", int'(ptr_hit_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset values through the window
    rd('hFC, 'h00, "R1 X");
    rd('hFD, 'h6F, "R1 SP");
    rd('hFE, 'h00, "R1 B");
    rd('hFF, 'h00, "R1 S");

    // R2/R3/R4: every segment against every direct address
    for (int s = 0; s < 256; s++) begin
      acc(1, 0, 'hFF, 0, 1, s);
      for (int a = 0; a < 256; a++) acc(1, 0, a, 0, 0, 0);
    end

    // R5: indirect via B over every pointer value, S = A7h
    acc(1, 0, 'hFF, 0, 1, 'hA7);
    for (int b = 0; b < 256; b++) begin
      acc(1, 0, 'hFE, 0, 1, b);
      acc(1, 1, 0, 0, 0, 0);
    end

    // R6/R7: B increments across the top and wraps
    acc(1, 0, 'hFE, 0, 1, 'hF8);
    for (int i = 0; i < 20; i++) acc(1, 1, 0, 1, 0, 0);
    rd('hFE, 'h0C, "R7 B wrap");

    // R7: X decrements below zero
    acc(1, 0, 'hFC, 0, 1, 'h03);
    for (int i = 0; i < 6; i++) acc(1, 2, 0, 2, 0, 0);
    rd('hFC, 'hFD, "R7 X wrap");

    // R6: reserved post code leaves B alone
    acc(1, 1, 0, 3, 0, 0);
    rd('hFE, 'h0C, "R6 code3");

    // R8: SP and direct modes ignore post_op
    acc(1, 0, 'hFD, 0, 1, 'h40);
    acc(1, 3, 0, 1, 0, 0);
    acc(1, 3, 0, 2, 0, 0);
    rd('hFD, 'h40, "R8 SP");
    acc(1, 0, 'h10, 1, 0, 0);
    rd('hFE, 'h0C, "R8 direct");
    rd('hFC, 'hFD, "R8 direct X");

    // R9: pointer writes itself while stepping
    acc(1, 0, 'hFE, 0, 1, 'hFE);
    acc(1, 1, 0, 1, 1, 'h33);
    rd('hFE, 'h33, "R9 B");
    acc(1, 0, 'hFC, 0, 1, 'hFC);
    acc(1, 2, 0, 2, 1, 'h77);
    rd('hFC, 'h77, "R9 X");

    // R10: idle request with write strobe
    acc(0, 0, 'hFE, 0, 1, 'h99);
    acc(0, 1, 0, 1, 1, 'h99);
    rd('hFE, 'h33, "R10");

    // R11: read with data present changes nothing
    acc(1, 0, 'hFF, 0, 0, 'h55);
    rd('hFF, 'hA7, "R11");

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule